// File: doc/BRIEF.md
# Half-Rate Interleaved Serial Delay Line

This block is a serial delay line of `DEPTH` stages whose output stream is bit-for-bit the stream a plain full-rate shift register would give. It is split into two banks of `DEPTH/2` flip-flops. Bits that arrive on even cycles after reset enter the even bank. Bits that arrive on odd cycles enter the odd bank. Each bank therefore advances only every second cycle. This halves the switching rate of every storage flip-flop, and the flip-flops keep the full supply voltage.

A two-state phase machine tracks which bank is due. Its states are `PH_EVEN` and `PH_ODD`. It takes the transition `PH_EVEN -> PH_ODD` and the transition `PH_ODD -> PH_EVEN` on every clock edge outside reset, and reset forces `PH_EVEN`. The phase gives each bank its shift enable, which stands in for a divided clock. `PH_EVEN` enables the even bank and `PH_ODD` enables the odd bank. The same phase drives an output multiplexer. While the machine is in a given state, the multiplexer presents the last stage of the bank that the state names. `DEPTH` must be even and at least 2. Any other value stops elaboration.

Top module: `halfrate_shreg`

## Requirements
- R1: Taking the first cycle after reset release as cycle 0, `dout` in cycle t equals the `din` value presented in cycle t-`DEPTH` for every t >= `DEPTH`.
- R2: After reset is released, `dout` is 0 for the first `DEPTH` cycles, whatever `din` carries.
- R3: A bit presented at an odd cycle index (counted from reset release) reaches `dout` exactly `DEPTH` cycles later, with no copy at any other cycle.
- R4: A bit presented at an even cycle index reaches `dout` exactly `DEPTH` cycles later, with no copy at any other cycle.
- R5: The minimum configuration, `DEPTH` = 2 with one flip-flop per bank, gives the same exact `DEPTH`-cycle delay.
- R6: Asserting reset in the middle of a stream clears both banks and the phase. The `DEPTH` outputs that follow the release are then 0, even when the banks held ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial input bit, one per cycle |
| dout | output | 1 | Serial output bit, delayed by `DEPTH` cycles |

## Verification
The bench builds the block twice and drives both copies from one stream. The first copy uses `DEPTH` = 16, with 8 stages per bank. The second uses `DEPTH` = 2, with a single stage per bank, which exposes the degenerate bank and the tightest path between phase and multiplexer. Every 9-bit word is serialised in turn, so every local bit pattern reaches both banks at both phase alignments. Isolated single ones at odd and even indices, an alternating stream, a mid-stream reset over a bank full of ones, and a pseudo-random tail complete the stimulus.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_t;

endpackage

// File: rtl/hrs_phase_fsm.sv
module hrs_phase_fsm
    import hrs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t phase,
    output logic   en_even,
    output logic   en_odd
);

    phase_t state_q;
    phase_t state_d;

    // next-state logic: the two banks take turns every full-rate cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_EVEN: state_d = PH_ODD;
            PH_ODD:  state_d = PH_EVEN;
            default: state_d = PH_EVEN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_EVEN;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs: one bank enable per state
    always_comb begin
        en_even = 1'b0;
        en_odd  = 1'b0;
        unique case (state_q)
            PH_EVEN: en_even = 1'b1;
            PH_ODD:  en_odd  = 1'b1;
            default: en_even = 1'b0;
        endcase
    end

    assign phase = state_q;

endmodule

// File: rtl/hrs_bank.sv
module hrs_bank #(
    parameter int LEN = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] taps,
    output logic           tail
);

    logic [LEN-1:0] stage_q;

    generate
        if (LEN == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q <= '0;
                end else if (shift_en) begin
                    stage_q <= din;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q <= '0;
                end else if (shift_en) begin
                    stage_q <= {stage_q[LEN-2:0], din};
                end
            end
        end
    endgenerate

    assign taps = stage_q;
    assign tail = stage_q[LEN-1];

endmodule

// File: rtl/hrs_outmux.sv
module hrs_outmux
    import hrs_pkg::*;
(
    input  phase_t phase,
    input  logic   even_tail,
    input  logic   odd_tail,
    output logic   dout
);

    // the bank captured in this phase DEPTH cycles ago holds the due bit
    always_comb begin
        dout = 1'b0;
        unique case (phase)
            PH_EVEN: dout = even_tail;
            PH_ODD:  dout = odd_tail;
            default: dout = 1'b0;
        endcase
    end

endmodule

// File: rtl/halfrate_shreg.sv
module halfrate_shreg
    import hrs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    localparam int HALF = DEPTH / 2;

    generate
        if ((DEPTH % 2) != 0 || DEPTH < 2) begin : g_bad_depth
            $error("halfrate_shreg: DEPTH must be even and at least 2");
        end
    endgenerate

    phase_t           phase;
    logic             en_even;
    logic             en_odd;
    logic [HALF-1:0]  even_taps;
    logic [HALF-1:0]  odd_taps;
    logic             even_tail;
    logic             odd_tail;

    hrs_phase_fsm u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .en_even (en_even),
        .en_odd  (en_odd)
    );

    hrs_bank #(.LEN(HALF)) u_even_bank (
        .clk      (clk),
        .rst      (rst),
        .shift_en (en_even),
        .din      (din),
        .taps     (even_taps),
        .tail     (even_tail)
    );

    hrs_bank #(.LEN(HALF)) u_odd_bank (
        .clk      (clk),
        .rst      (rst),
        .shift_en (en_odd),
        .din      (din),
        .taps     (odd_taps),
        .tail     (odd_tail)
    );

    hrs_outmux u_mux (
        .phase     (phase),
        .even_tail (even_tail),
        .odd_tail  (odd_tail),
        .dout      (dout)
    );

endmodule

// File: rtl/hrs_checker.sv
module hrs_checker
    import hrs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 din,
    input  logic                 dout,
    input  phase_t               phase,
    input  logic [DEPTH/2-1:0]   even_taps,
    input  logic [DEPTH/2-1:0]   odd_taps
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst < CW'(DEPTH)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    // R2 / R6: quiet output window after any reset
    a_r2_zero_after_reset: assert property (@(posedge clk) disable iff (rst)
        (since_rst < CW'(DEPTH)) |-> (dout == 1'b0));

    // R1: phase begins even and alternates every cycle
    a_r1_phase_starts_even: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (phase == PH_EVEN));

    a_r1_phase_alternates: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (phase != $past(phase)));

    // R4: even bank captures din in even phase, odd bank holds
    a_r4_even_capture: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(phase) == PH_EVEN) |-> (even_taps[0] == $past(din)));

    a_r4_odd_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(phase) == PH_EVEN) |-> $stable(odd_taps));

    // R3: odd bank captures din in odd phase, even bank holds
    a_r3_odd_capture: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(phase) == PH_ODD) |-> (odd_taps[0] == $past(din)));

    a_r3_even_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(phase) == PH_ODD) |-> $stable(even_taps));

endmodule

bind halfrate_shreg hrs_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .dout      (dout),
    .phase     (phase),
    .even_taps (even_taps),
    .odd_taps  (odd_taps)
);

// File: tb/tb_halfrate_shreg.sv
`timescale 1ns/1ps
module tb_halfrate_shreg;

    localparam int L_MAIN  = 16;
    localparam int L_SHORT = 2;
    localparam int HMAX    = 16384;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic dout_main;
    logic dout_short;

    int compared   = 0;
    int mismatched = 0;
    int t          = 0;
    bit hist [0:HMAX-1];
    string zero_tag = "R2";
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    halfrate_shreg #(.DEPTH(L_MAIN)) dut (
        .clk (clk), .rst (rst), .din (din), .dout (dout_main)
    );

    halfrate_shreg #(.DEPTH(L_SHORT)) dut_short (
        .clk (clk), .rst (rst), .din (din), .dout (dout_short)
    );

    function automatic bit expect_bit(int depth);
        if (t < depth) return 1'b0;
        return hist[(t - depth) % HMAX];
    endfunction

    task automatic check_one(logic got, bit exp, string tag, string who);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s %s cycle %0d: got %b expected %b", tag, who, t, got, exp);
        end
    endtask

    // check this cycle's outputs, then drive the bit for this cycle
    task automatic step(bit b, string tag);
        check_one(dout_main, expect_bit(L_MAIN),
                  (t < L_MAIN) ? zero_tag : tag, "depth16");
        check_one(dout_short, expect_bit(L_SHORT),
                  (t < L_SHORT) ? zero_tag : "R5", "depth2");
        hist[t % HMAX] = b;
        din = b;
        t++;
        @(negedge clk);
    endtask

    task automatic do_reset(string tag);
        rst = 1'b1;
        din = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t = 0;
        zero_tag = tag;
    endtask

    task automatic flush(int n, string tag);
        for (int i = 0; i < n; i++) step(1'b0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R2: reset state, din held high through reset
        do_reset("R2");
        for (int i = 0; i < 20; i++) step(1'b1, "R1");

        // R4: isolated one at an even index
        do_reset("R2");
        flush(4, "R4");
        step(1'b1, "R4");
        flush(2 * L_MAIN, "R4");

        // R3: isolated one at an odd index
        do_reset("R2");
        flush(5, "R3");
        step(1'b1, "R3");
        flush(2 * L_MAIN, "R3");

        // R1: alternating stream, both alignments
        for (int i = 0; i < 64; i++) step(i[0], "R1");
        for (int i = 0; i < 64; i++) step(~i[0], "R1");

        // R1: every 9-bit word serialised
        for (int w = 0; w < 512; w++) begin
            for (int k = 0; k < 9; k++) step(w[k], "R1");
        end

        // R6: load ones, reset mid-stream, expect a quiet window
        for (int i = 0; i < 40; i++) step(1'b1, "R1");
        do_reset("R6");
        for (int i = 0; i < 40; i++) step(1'b0, "R6");
        for (int i = 0; i < 20; i++) step(1'b1, "R1");

        // R1: pseudo-random tail
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], "R1");
        end
        flush(L_MAIN + 2, "R1");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule